// File: doc/BRIEF.md
# Key-Locked Indexed Configuration Port

This block is a configuration register file that a host reaches through two byte-wide ports sharing one small bus: an index port that names a register and a data port that moves that register's value. The register file is locked after reset. It opens only when a fixed unlock key byte has been written to the index port on two consecutive index writes. A second, different key byte written to the index port locks it again.

Registers are split into a global space and a banked space. Global registers include a logical-device selector and read-only chip and vendor identification words. Register numbers at or above 0x30 belong to the bank of the logical device currently named by the selector. Each logical device holds an enable flag, a 16-bit I/O base address and an IRQ number, and the block drives these values straight out to the rest of the chip.

Top module: `cfg_port_ctrl`

## Requirements
- R1: After reset the port is locked, the device selector is 0, the stored index is 0, and every device output (enable, base, IRQ) is zero.
- R2: The port opens only after two consecutive index-port writes of KEY_ON (default 0x5A). Neither unlock write changes the stored index.
- R3: While locked, an index-port write of any byte other than KEY_ON restarts the unlock count, so KEY_ON, other byte, KEY_ON leaves the port locked.
- R4: While open, an index-port write of KEY_OFF (default 0xC3) locks the port. The key is not stored as an index.
- R5: A read returns 0xFF when the port is locked or when the chip select is low, on either port.
- R6: Data-port writes while locked change no register.
- R7: While open, an index-port write stores the register number, and an index-port read returns it. Data-port accesses act on the register that the stored index names.
- R8: Global register 0x07 holds the logical device number. It is readable and writable, and it picks the bank that registers at 0x30 and above address.
- R9: Bank registers are 0x30 (enable in bit 0, read back as 0x00 or 0x01), 0x60 (base bits 15:8), 0x61 (base bits 7:0) and 0x70 (IRQ). They drive dev_enable, dev_base and dev_irq at the slot of that device.
- R10: Global registers 0x20/0x21 return CHIP_ID high/low and 0x22/0x23 return VENDOR_ID high/low. Data writes to them are ignored.
- R11: When the device number is NUM_DEV or above, bank reads return 0x00 and bank writes change no device.
- R12: Unmapped register numbers read as 0x00 while open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_cs | input | 1 | Chip select: the port pair is claimed |
| bus_addr | input | 1 | 0 selects the index port, 1 selects the data port |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe (read data is combinational) |
| bus_wdata | input | 8 | Write byte |
| bus_rdata | output | 8 | Read byte |
| dev_enable | output | NUM_DEV | Enable flag of each logical device |
| dev_base | output | 16*NUM_DEV | I/O base of each device, device i at bits 16i+15:16i |
| dev_irq | output | 8*NUM_DEV | IRQ number of each device, device i at bits 8i+7:8i |

## Verification
The bench builds the block with NUM_DEV set to 3, CHIP_ID set to 0x4B21 and VENDOR_ID set to 0x1C0E, and keeps the default keys. Three devices make it possible to select device number 5, so the out-of-range bank behaviour can be tested. With distinct ID bytes, a swap between the high and low byte, or between chip and vendor, shows up in a read. Keeping the default keys lets the interrupted-sequence case and the relock case use the key values that ship.

// File: rtl/cfgp_pkg.sv
package cfgp_pkg;

    typedef enum logic [1:0] {
        LK_CLOSED = 2'd0,
        LK_HALF   = 2'd1,
        LK_OPEN   = 2'd2
    } lock_st_e;

    typedef enum logic [2:0] {
        FLD_NONE = 3'd0,
        FLD_EN   = 3'd1,
        FLD_BHI  = 3'd2,
        FLD_BLO  = 3'd3,
        FLD_IRQ  = 3'd4
    } dev_fld_e;

    typedef struct packed {
        logic        en;
        logic [15:0] base;
        logic [7:0]  irq;
    } dev_cfg_t;

    localparam logic [7:0] REG_LDN      = 8'h07;
    localparam logic [7:0] REG_CHIP_HI  = 8'h20;
    localparam logic [7:0] REG_CHIP_LO  = 8'h21;
    localparam logic [7:0] REG_VEND_HI  = 8'h22;
    localparam logic [7:0] REG_VEND_LO  = 8'h23;
    localparam logic [7:0] BANK_START   = 8'h30;
    localparam logic [7:0] REG_DEV_EN   = 8'h30;
    localparam logic [7:0] REG_BASE_HI  = 8'h60;
    localparam logic [7:0] REG_BASE_LO  = 8'h61;
    localparam logic [7:0] REG_IRQ_SEL  = 8'h70;

    localparam logic PORT_INDEX = 1'b0;
    localparam logic PORT_DATA  = 1'b1;

    function automatic dev_fld_e decode_field(input logic [7:0] idx);
        dev_fld_e f;
        case (idx)
            REG_DEV_EN:  f = FLD_EN;
            REG_BASE_HI: f = FLD_BHI;
            REG_BASE_LO: f = FLD_BLO;
            REG_IRQ_SEL: f = FLD_IRQ;
            default:     f = FLD_NONE;
        endcase
        return f;
    endfunction

    function automatic logic [7:0] field_value(input dev_cfg_t c, input dev_fld_e f);
        logic [7:0] v;
        case (f)
            FLD_EN:  v = {7'd0, c.en};
            FLD_BHI: v = c.base[15:8];
            FLD_BLO: v = c.base[7:0];
            FLD_IRQ: v = c.irq;
            default: v = 8'h00;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/cfgp_unlock.sv
module cfgp_unlock
    import cfgp_pkg::*;
#(
    parameter logic [7:0] KEY_ON  = 8'h5A,
    parameter logic [7:0] KEY_OFF = 8'hC3
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       idx_wr,
    input  logic [7:0] wdata,
    output logic       unlocked,
    output logic       idx_load
);

    lock_st_e st_q, st_d;

    always_comb begin
        st_d     = st_q;
        idx_load = 1'b0;
        if (idx_wr) begin
            case (st_q)
                LK_CLOSED: st_d = (wdata == KEY_ON) ? LK_HALF : LK_CLOSED;
                LK_HALF:   st_d = (wdata == KEY_ON) ? LK_OPEN : LK_CLOSED;
                LK_OPEN: begin
                    if (wdata == KEY_OFF) st_d = LK_CLOSED;
                    else                  idx_load = 1'b1;
                end
                default:   st_d = LK_CLOSED;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= LK_CLOSED;
        else     st_q <= st_d;
    end

    assign unlocked = (st_q == LK_OPEN);

endmodule

// File: rtl/cfgp_dev_bank.sv
module cfgp_dev_bank
    import cfgp_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  dev_fld_e   field,
    input  logic [7:0] wdata,
    output dev_cfg_t   cfg
);

    dev_cfg_t cfg_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else if (wr_en) begin
            case (field)
                FLD_EN:  cfg_q.en         <= wdata[0];
                FLD_BHI: cfg_q.base[15:8] <= wdata;
                FLD_BLO: cfg_q.base[7:0]  <= wdata;
                FLD_IRQ: cfg_q.irq        <= wdata;
                default: ;
            endcase
        end
    end

    assign cfg = cfg_q;

endmodule

// File: rtl/cfg_port_ctrl.sv
module cfg_port_ctrl
    import cfgp_pkg::*;
#(
    parameter int          NUM_DEV   = 4,
    parameter logic [7:0]  KEY_ON    = 8'h5A,
    parameter logic [7:0]  KEY_OFF   = 8'hC3,
    parameter logic [15:0] CHIP_ID   = 16'h4B21,
    parameter logic [15:0] VENDOR_ID = 16'h1C0E
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    bus_cs,
    input  logic                    bus_addr,
    input  logic                    bus_wr,
    input  logic                    bus_rd,
    input  logic [7:0]              bus_wdata,
    output logic [7:0]              bus_rdata,
    output logic [NUM_DEV-1:0]      dev_enable,
    output logic [16*NUM_DEV-1:0]   dev_base,
    output logic [8*NUM_DEV-1:0]    dev_irq
);

    localparam int BASE_W = 16;
    localparam int IRQ_W  = 8;

    logic       idx_wr, data_wr;
    logic       unlocked, idx_load;
    logic [7:0] idx_q, ldn_q;
    dev_fld_e   fld;
    logic       in_bank;
    logic       ldn_valid;
    dev_cfg_t   sel_cfg;
    dev_cfg_t   cfg_arr [NUM_DEV];

    assign idx_wr  = bus_cs && bus_wr && (bus_addr == PORT_INDEX);
    assign data_wr = bus_cs && bus_wr && (bus_addr == PORT_DATA) && unlocked;

    cfgp_unlock #(
        .KEY_ON  (KEY_ON),
        .KEY_OFF (KEY_OFF)
    ) u_unlock (
        .clk      (clk),
        .rst      (rst),
        .idx_wr   (idx_wr),
        .wdata    (bus_wdata),
        .unlocked (unlocked),
        .idx_load (idx_load)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            idx_q <= 8'h00;
            ldn_q <= 8'h00;
        end else begin
            if (idx_load) idx_q <= bus_wdata;
            if (data_wr && idx_q == REG_LDN) ldn_q <= bus_wdata;
        end
    end

    assign fld     = decode_field(idx_q);
    assign in_bank = (idx_q >= BANK_START);

    always_comb begin
        ldn_valid = 1'b0;
        sel_cfg   = '0;
        for (int i = 0; i < NUM_DEV; i++) begin
            if (ldn_q == 8'(i)) begin
                ldn_valid = 1'b1;
                sel_cfg   = cfg_arr[i];
            end
        end
    end

    generate
        for (genvar g = 0; g < NUM_DEV; g++) begin : g_dev
            logic bank_we;
            assign bank_we = data_wr && in_bank && (ldn_q == 8'(g));

            cfgp_dev_bank u_bank (
                .clk   (clk),
                .rst   (rst),
                .wr_en (bank_we),
                .field (fld),
                .wdata (bus_wdata),
                .cfg   (cfg_arr[g])
            );

            assign dev_enable[g]                  = cfg_arr[g].en;
            assign dev_base[g*BASE_W +: BASE_W]   = cfg_arr[g].base;
            assign dev_irq[g*IRQ_W +: IRQ_W]      = cfg_arr[g].irq;
        end
    endgenerate

    always_comb begin
        bus_rdata = 8'hFF;
        if (bus_cs && bus_rd && unlocked) begin
            if (bus_addr == PORT_INDEX) begin
                bus_rdata = idx_q;
            end else if (in_bank) begin
                bus_rdata = ldn_valid ? field_value(sel_cfg, fld) : 8'h00;
            end else begin
                case (idx_q)
                    REG_LDN:     bus_rdata = ldn_q;
                    REG_CHIP_HI: bus_rdata = CHIP_ID[15:8];
                    REG_CHIP_LO: bus_rdata = CHIP_ID[7:0];
                    REG_VEND_HI: bus_rdata = VENDOR_ID[15:8];
                    REG_VEND_LO: bus_rdata = VENDOR_ID[7:0];
                    default:     bus_rdata = 8'h00;
                endcase
            end
        end
    end

endmodule

// File: rtl/cfgp_checker.sv
module cfgp_checker #(
    parameter int         NUM_DEV = 4,
    parameter logic [7:0] KEY_ON  = 8'h5A,
    parameter logic [7:0] KEY_OFF = 8'hC3
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  bus_cs,
    input logic                  bus_addr,
    input logic                  bus_wr,
    input logic                  bus_rd,
    input logic [7:0]            bus_wdata,
    input logic [7:0]            bus_rdata,
    input logic                  unlocked,
    input logic [NUM_DEV-1:0]    dev_enable,
    input logic [16*NUM_DEV-1:0] dev_base,
    input logic [8*NUM_DEV-1:0]  dev_irq
);

    logic idx_wr_on, idx_wr_off;
    assign idx_wr_on  = bus_cs && bus_wr && !bus_addr && (bus_wdata == KEY_ON);
    assign idx_wr_off = bus_cs && bus_wr && !bus_addr && (bus_wdata == KEY_OFF);

    assert_open_needs_key_R2: assert property (@(posedge clk) disable iff (rst)
        (unlocked && !$past(unlocked)) |-> $past(idx_wr_on));

    assert_off_key_locks_R4: assert property (@(posedge clk) disable iff (rst)
        (unlocked && idx_wr_off) |=> !unlocked);

    assert_closed_reads_ff_R5: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && (!bus_cs || !unlocked)) |-> (bus_rdata == 8'hFF));

    assert_locked_no_change_R6: assert property (@(posedge clk) disable iff (rst)
        !$past(unlocked) |-> ($stable(dev_enable) && $stable(dev_base) && $stable(dev_irq)));

    assert_one_step_open_R3: assert property (@(posedge clk) disable iff (rst)
        (!unlocked && !$past(unlocked) && !idx_wr_on) |=> !unlocked);

endmodule

bind cfg_port_ctrl cfgp_checker #(
    .NUM_DEV (NUM_DEV),
    .KEY_ON  (KEY_ON),
    .KEY_OFF (KEY_OFF)
) u_cfgp_checker (
    .clk        (clk),
    .rst        (rst),
    .bus_cs     (bus_cs),
    .bus_addr   (bus_addr),
    .bus_wr     (bus_wr),
    .bus_rd     (bus_rd),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .unlocked   (unlocked),
    .dev_enable (dev_enable),
    .dev_base   (dev_base),
    .dev_irq    (dev_irq)
);

// File: tb/cfg_port_ctrl_bench.sv
module cfg_port_ctrl_bench;

    localparam int          ND    = 3;
    localparam logic [15:0] CHIP  = 16'h4B21;
    localparam logic [15:0] VEND  = 16'h1C0E;
    localparam logic [1:0]  OPW   = 2'b01;
    localparam logic [1:0]  OPR   = 2'b10;
    localparam int          NV    = 45;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              bus_cs = 1'b0, bus_addr = 1'b0, bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0]        bus_wdata = 8'h00;
    logic [7:0]        bus_rdata;
    logic [ND-1:0]     dev_enable;
    logic [16*ND-1:0]  dev_base;
    logic [8*ND-1:0]   dev_irq;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    cfg_port_ctrl #(
        .NUM_DEV   (ND),
        .CHIP_ID   (CHIP),
        .VENDOR_ID (VEND)
    ) u_cfg_port_ctrl (
        .clk        (clk),
        .rst        (rst),
        .bus_cs     (bus_cs),
        .bus_addr   (bus_addr),
        .bus_wr     (bus_wr),
        .bus_rd     (bus_rd),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .dev_enable (dev_enable),
        .dev_base   (dev_base),
        .dev_irq    (dev_irq)
    );

    // {requirement number, op, port, value}; port 0 = index, 1 = data
    localparam logic [14:0] VEC [NV] = '{
        {4'd5,  OPR, 1'b1, 8'hFF},   // R5 locked data read
        {4'd5,  OPR, 1'b0, 8'hFF},   // R5 locked index read
        {4'd3,  OPW, 1'b0, 8'h5A},
        {4'd3,  OPW, 1'b0, 8'h20},   // R3 breaks the sequence
        {4'd3,  OPW, 1'b0, 8'h5A},
        {4'd3,  OPR, 1'b1, 8'hFF},   // R3 still locked
        {4'd2,  OPW, 1'b0, 8'h5A},   // R2 second key in a row
        {4'd2,  OPR, 1'b0, 8'h00},   // R2 open, index untouched
        {4'd10, OPW, 1'b0, 8'h20},
        {4'd10, OPR, 1'b1, 8'h4B},   // R10
        {4'd10, OPW, 1'b0, 8'h21},
        {4'd10, OPR, 1'b1, 8'h21},
        {4'd10, OPW, 1'b0, 8'h22},
        {4'd10, OPR, 1'b1, 8'h1C},
        {4'd10, OPW, 1'b0, 8'h23},
        {4'd10, OPR, 1'b1, 8'h0E},
        {4'd10, OPW, 1'b0, 8'h20},
        {4'd10, OPW, 1'b1, 8'h00},   // R10 write to ID ignored
        {4'd10, OPR, 1'b1, 8'h4B},
        {4'd8,  OPW, 1'b0, 8'h07},
        {4'd8,  OPW, 1'b1, 8'h01},
        {4'd8,  OPR, 1'b1, 8'h01},   // R8 selector readback
        {4'd9,  OPW, 1'b0, 8'h60},
        {4'd9,  OPW, 1'b1, 8'h12},
        {4'd9,  OPW, 1'b0, 8'h61},
        {4'd9,  OPW, 1'b1, 8'h34},
        {4'd9,  OPW, 1'b0, 8'h70},
        {4'd9,  OPW, 1'b1, 8'h05},
        {4'd9,  OPW, 1'b0, 8'h30},
        {4'd9,  OPW, 1'b1, 8'h01},
        {4'd9,  OPR, 1'b1, 8'h01},   // R9 enable readback
        {4'd7,  OPR, 1'b0, 8'h30},   // R7 index readback
        {4'd9,  OPW, 1'b0, 8'h60},
        {4'd9,  OPR, 1'b1, 8'h12},
        {4'd8,  OPW, 1'b0, 8'h07},
        {4'd8,  OPW, 1'b1, 8'h00},
        {4'd8,  OPW, 1'b0, 8'h60},
        {4'd8,  OPR, 1'b1, 8'h00},   // R8 device 0 bank is separate
        {4'd12, OPW, 1'b0, 8'h40},
        {4'd12, OPR, 1'b1, 8'h00},   // R12 unmapped bank register
        {4'd12, OPW, 1'b0, 8'h05},
        {4'd12, OPR, 1'b1, 8'h00},   // R12 unmapped global register
        {4'd4,  OPW, 1'b0, 8'hC3},
        {4'd4,  OPR, 1'b1, 8'hFF},   // R4 relocked
        {4'd4,  OPR, 1'b0, 8'hFF}
    };

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic port, input logic [7:0] d);
        @(negedge clk);
        bus_cs = 1'b1; bus_wr = 1'b1; bus_addr = port; bus_wdata = d;
        @(negedge clk);
        bus_cs = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic port, input logic cs, input logic [7:0] exp, input string req);
        @(negedge clk);
        bus_cs = cs; bus_rd = 1'b1; bus_addr = port;
        #1;
        check(req, 64'(bus_rdata), 64'(exp));
        bus_cs = 1'b0; bus_rd = 1'b0;
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        check("R1", 64'({dev_enable, dev_base, dev_irq}), 64'd0);
        for (int i = 0; i < NV; i++) begin
            if (VEC[i][10:9] == OPW) wr(VEC[i][8], VEC[i][7:0]);
            else rd(VEC[i][8], 1'b1, VEC[i][7:0], $sformatf("R%0d vec%0d", VEC[i][14:11], i));
        end
        // R9 port outputs of device 1
        check("R9", 64'(dev_enable), 64'(3'b010));
        check("R9", 64'(dev_base), 64'({16'h0000, 16'h1234, 16'h0000}));
        check("R9", 64'(dev_irq), 64'({8'h00, 8'h05, 8'h00}));
        // R6 locked data write
        wr(1'b0, 8'h5A); wr(1'b0, 8'h5A);
        wr(1'b0, 8'h07); wr(1'b1, 8'h01); wr(1'b0, 8'h70);
        wr(1'b0, 8'hC3);
        wr(1'b1, 8'h77);
        check("R6", 64'(dev_irq), 64'({8'h00, 8'h05, 8'h00}));
        wr(1'b0, 8'h5A); wr(1'b0, 8'h5A);
        rd(1'b1, 1'b1, 8'h05, "R6");
        // R11 out-of-range device
        wr(1'b0, 8'h07); wr(1'b1, 8'h05);
        wr(1'b0, 8'h70); wr(1'b1, 8'h99);
        rd(1'b1, 1'b1, 8'h00, "R11");
        check("R11", 64'(dev_irq), 64'({8'h00, 8'h05, 8'h00}));
        // R5 unclaimed read while open
        rd(1'b1, 1'b0, 8'hFF, "R5");
        // R1 reset again
        @(negedge clk); rst = 1'b1;
        repeat (2) @(negedge clk); rst = 1'b0;
        check("R1", 64'({dev_enable, dev_base, dev_irq}), 64'd0);
        rd(1'b1, 1'b1, 8'hFF, "R1");
        wr(1'b0, 8'h5A); wr(1'b0, 8'h5A);
        rd(1'b0, 1'b1, 8'h00, "R1");
        wr(1'b0, 8'h07);
        rd(1'b1, 1'b1, 8'h00, "R1");
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule